// File: doc/BRIEF.md
# Memory Access Fault Checker

This block watches every instruction fetch, load and store issued by a processor pipeline and decides, one access at a time, whether it has to be turned into a hardware exception. It checks three things: whether the address is aligned to the access size, whether a stack-checked access falls outside the window set by a low and a high limit, and whether the instruction-side or data-side bus reported an error for the current access.

When a fault is accepted, the block loads a fault-address register with the access address and a syndrome register with a packed description of the fault. It also raises a one-cycle exception request. Each fault class is gated in its own way. Misalignment is always recorded, but it raises the request only when exceptions are enabled. A stack violation always raises. Bus errors are dropped entirely while exceptions are disabled, and otherwise their reporting depends on a per-side configuration enable. Address translation and the bus itself belong to other blocks.

Top module: `mem_fault_chk`

## Requirements
- R1: While `rst` is high, `fault_addr`, `fault_syn` and `exc_req` become zero on each clock edge.
- R2: A valid access is misaligned when `acc_addr[1:0] & acc_size` is nonzero; `acc_size` is 0 for byte, 1 for halfword and 3 for word. On misalignment the syndrome becomes: bits [4:0] = 1 (unaligned cause), bits [9:5] = `acc_reg`, bit 10 = `acc_write`, bit 11 = 1 exactly when `acc_size` is 3. `fault_addr` takes `acc_addr`.
- R3: A misalignment updates `fault_addr` and `fault_syn` whatever `exc_en` is, and it pulses `exc_req` only when `exc_en` is 1.
- R4: An aligned valid access that is neither a stack violation nor accompanied by an accepted bus error leaves `fault_addr` and `fault_syn` unchanged and gives `exc_req` = 0.
- R5: With `stk_chk_en` = 1, a valid access with `acc_addr < stk_lo` or `acc_addr > stk_hi` (unsigned) loads `fault_addr`, sets the syndrome to 7 (all other bits zero) and pulses `exc_req` whatever `exc_en` is. Addresses equal to either limit pass.
- R6: With `stk_chk_en` = 0, no address causes a stack fault.
- R7: When `exc_en` = 0, `ibus_err` and `dbus_err` have no effect at all.
- R8: When `exc_en` = 1 and a bus error is present, `fault_addr` takes `acc_addr`. If the side's configuration enable is set, the syndrome becomes 3 for the instruction side or 4 for the data side, and `exc_req` pulses. The instruction side wins when both strobes are high.
- R9: An accepted bus error whose side is not configured captures `fault_addr` only. `fault_syn` holds, `exc_req` stays 0, and no lower-priority check is recorded in that cycle.
- R10: When several checks fire in one cycle, the order of priority is accepted bus error, then misalignment, then stack violation.
- R11: Results appear on the clock edge that samples the access. `exc_req` is high for that single cycle only and drops after an idle cycle.
- R12: With `acc_valid` = 0, neither the alignment check nor the stack check fires.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| acc_valid | input | 1 | An access is presented this cycle |
| acc_addr | input | ADDR_W | Access address |
| acc_size | input | 2 | Size mask: 0 byte, 1 halfword, 3 word |
| acc_write | input | 1 | 1 for a store |
| acc_reg | input | 5 | Register index of the access |
| stk_chk_en | input | 1 | Apply the stack window to this access |
| stk_lo | input | ADDR_W | Lowest allowed stack address |
| stk_hi | input | ADDR_W | Highest allowed stack address |
| ibus_err | input | 1 | Instruction-side bus error strobe |
| dbus_err | input | 1 | Data-side bus error strobe |
| exc_en | input | 1 | Exceptions enabled |
| cfg_ibus_exc | input | 1 | Report instruction-side bus errors |
| cfg_dbus_exc | input | 1 | Report data-side bus errors |
| fault_addr | output | ADDR_W | Captured faulting address |
| fault_syn | output | 12 | Captured fault syndrome |
| exc_req | output | 1 | One-cycle exception request |

## Verification
Every result of this block is due exactly one clock edge after the access is presented: the address register, the syndrome register and the exception pulse all load on the edge that samples the inputs. The bench drives an access on a falling edge and compares all three outputs on the following falling edge. It then presents the next access, so each comparison sees the effect of exactly one access. A separate idle cycle after a raising access confirms that the request falls back to zero one edge later.

// File: rtl/fault_pkg.sv
package fault_pkg;
  localparam int CAUSE_W  = 5;
  localparam int REG_W    = 5;
  localparam int REG_LSB  = CAUSE_W;
  localparam int WR_BIT   = REG_LSB + REG_W;
  localparam int WORD_BIT = WR_BIT + 1;
  localparam int SYN_W    = WORD_BIT + 1;

  localparam logic [CAUSE_W-1:0] CAUSE_UNALIGNED = 5'd1;
  localparam logic [CAUSE_W-1:0] CAUSE_IBUS      = 5'd3;
  localparam logic [CAUSE_W-1:0] CAUSE_DBUS      = 5'd4;
  localparam logic [CAUSE_W-1:0] CAUSE_STACK     = 5'd7;

  typedef struct packed {
    logic             cap_addr;
    logic             load_syn;
    logic             raise;
    logic [SYN_W-1:0] syn;
  } fault_dec_t;
endpackage

// File: rtl/misalign_det.sv
module misalign_det #(
  parameter int ADDR_W = 32
) (
  input  logic              valid,
  input  logic [ADDR_W-1:0] addr,
  input  logic [1:0]        size_mask,
  output logic              hit
);
  always_comb hit = valid && ((addr[1:0] & size_mask) != 2'b00);
endmodule

// File: rtl/stack_guard.sv
module stack_guard #(
  parameter int ADDR_W = 32
) (
  input  logic              valid,
  input  logic              enable,
  input  logic [ADDR_W-1:0] addr,
  input  logic [ADDR_W-1:0] lo,
  input  logic [ADDR_W-1:0] hi,
  output logic              viol
);
  logic below, above;
  always_comb begin
    below = addr < lo;
    above = addr > hi;
    viol  = valid && enable && (below || above);
  end
endmodule

// File: rtl/fault_arbiter.sv
module fault_arbiter
  import fault_pkg::*;
(
  input  logic             mis_hit,
  input  logic             stk_viol,
  input  logic             ibus_err,
  input  logic             dbus_err,
  input  logic             exc_en,
  input  logic             cfg_ibus_exc,
  input  logic             cfg_dbus_exc,
  input  logic             acc_write,
  input  logic [REG_W-1:0] acc_reg,
  input  logic [1:0]       acc_size,
  output fault_dec_t       dec
);
  logic bus_taken;

  always_comb begin
    bus_taken = exc_en && (ibus_err || dbus_err);
    dec       = '0;
    if (bus_taken) begin
      dec.cap_addr = 1'b1;
      if (ibus_err) begin
        if (cfg_ibus_exc) begin
          dec.load_syn            = 1'b1;
          dec.raise               = 1'b1;
          dec.syn[CAUSE_W-1:0]    = CAUSE_IBUS;
        end
      end else if (cfg_dbus_exc) begin
        dec.load_syn            = 1'b1;
        dec.raise               = 1'b1;
        dec.syn[CAUSE_W-1:0]    = CAUSE_DBUS;
      end
    end else if (mis_hit) begin
      dec.cap_addr               = 1'b1;
      dec.load_syn               = 1'b1;
      dec.raise                  = exc_en;
      dec.syn[CAUSE_W-1:0]       = CAUSE_UNALIGNED;
      dec.syn[REG_LSB +: REG_W]  = acc_reg;
      dec.syn[WR_BIT]            = acc_write;
      dec.syn[WORD_BIT]          = (acc_size == 2'b11);
    end else if (stk_viol) begin
      dec.cap_addr               = 1'b1;
      dec.load_syn               = 1'b1;
      dec.raise                  = 1'b1;
      dec.syn[CAUSE_W-1:0]       = CAUSE_STACK;
    end
  end
endmodule

// File: rtl/mem_fault_chk.sv
module mem_fault_chk
  import fault_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              acc_valid,
  input  logic [ADDR_W-1:0] acc_addr,
  input  logic [1:0]        acc_size,
  input  logic              acc_write,
  input  logic [REG_W-1:0]  acc_reg,
  input  logic              stk_chk_en,
  input  logic [ADDR_W-1:0] stk_lo,
  input  logic [ADDR_W-1:0] stk_hi,
  input  logic              ibus_err,
  input  logic              dbus_err,
  input  logic              exc_en,
  input  logic              cfg_ibus_exc,
  input  logic              cfg_dbus_exc,
  output logic [ADDR_W-1:0] fault_addr,
  output logic [SYN_W-1:0]  fault_syn,
  output logic              exc_req
);
  logic       mis_hit;
  logic       stk_viol;
  fault_dec_t dec;

  misalign_det #(.ADDR_W(ADDR_W)) u_align (
    .valid(acc_valid), .addr(acc_addr), .size_mask(acc_size), .hit(mis_hit)
  );

  stack_guard #(.ADDR_W(ADDR_W)) u_stack (
    .valid(acc_valid), .enable(stk_chk_en), .addr(acc_addr),
    .lo(stk_lo), .hi(stk_hi), .viol(stk_viol)
  );

  fault_arbiter u_arb (
    .mis_hit(mis_hit), .stk_viol(stk_viol), .ibus_err(ibus_err),
    .dbus_err(dbus_err), .exc_en(exc_en), .cfg_ibus_exc(cfg_ibus_exc),
    .cfg_dbus_exc(cfg_dbus_exc), .acc_write(acc_write), .acc_reg(acc_reg),
    .acc_size(acc_size), .dec(dec)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      fault_addr <= '0;
      fault_syn  <= '0;
      exc_req    <= 1'b0;
    end else begin
      if (dec.cap_addr) fault_addr <= acc_addr;
      if (dec.load_syn) fault_syn  <= dec.syn;
      exc_req <= dec.raise;
    end
  end
endmodule

// File: rtl/mem_fault_chk_sva.sv
module mem_fault_chk_sva
  import fault_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              rst,
  input logic              acc_valid,
  input logic [ADDR_W-1:0] acc_addr,
  input logic [1:0]        acc_size,
  input logic              stk_chk_en,
  input logic [ADDR_W-1:0] stk_lo,
  input logic              ibus_err,
  input logic              dbus_err,
  input logic              exc_en,
  input logic [ADDR_W-1:0] fault_addr,
  input logic [SYN_W-1:0]  fault_syn,
  input logic              exc_req
);
  AST_RESET_CLEARS: assert property (@(posedge clk)
    rst |=> (fault_addr == '0 && fault_syn == '0 && !exc_req)); // R1

  AST_QUIET_WHEN_DISABLED: assert property (@(posedge clk) disable iff (rst)
    (!acc_valid && !exc_en) |=> (!exc_req && $stable(fault_addr) && $stable(fault_syn))); // R7

  AST_MISALIGN_NO_RAISE: assert property (@(posedge clk) disable iff (rst)
    (acc_valid && ((acc_addr[1:0] & acc_size) != 2'b00) && !exc_en)
      |=> (!exc_req && fault_syn[CAUSE_W-1:0] == CAUSE_UNALIGNED)); // R3

  AST_STACK_LOW_RAISES: assert property (@(posedge clk) disable iff (rst)
    (acc_valid && stk_chk_en && ((acc_addr[1:0] & acc_size) == 2'b00)
      && !ibus_err && !dbus_err && (acc_addr < stk_lo))
      |=> (exc_req && fault_syn == SYN_W'(CAUSE_STACK))); // R5

  AST_ADDR_FOLLOWS_RAISE: assert property (@(posedge clk) disable iff (rst)
    exc_req |-> (fault_addr == $past(acc_addr))); // R11
endmodule

bind mem_fault_chk mem_fault_chk_sva #(.ADDR_W(ADDR_W)) u_sva (
  .clk(clk), .rst(rst), .acc_valid(acc_valid), .acc_addr(acc_addr),
  .acc_size(acc_size), .stk_chk_en(stk_chk_en), .stk_lo(stk_lo),
  .ibus_err(ibus_err), .dbus_err(dbus_err), .exc_en(exc_en),
  .fault_addr(fault_addr), .fault_syn(fault_syn), .exc_req(exc_req)
);

// File: tb/test_mem_fault_chk.sv
module test_mem_fault_chk;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 32;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          acc_valid = 1'b0;
  logic [AW-1:0] acc_addr = '0;
  logic [1:0]    acc_size = '0;
  logic          acc_write = 1'b0;
  logic [4:0]    acc_reg = '0;
  logic          stk_chk_en = 1'b0;
  logic [AW-1:0] stk_lo = 32'h0000_0100;
  logic [AW-1:0] stk_hi = 32'h0000_01FF;
  logic          ibus_err = 1'b0, dbus_err = 1'b0, exc_en = 1'b0;
  logic          cfg_ibus_exc = 1'b0, cfg_dbus_exc = 1'b0;
  logic [AW-1:0] fault_addr;
  logic [11:0]   fault_syn;
  logic          exc_req;

  int total = 0;
  int bad = 0;
  logic [AW-1:0] m_addr = '0;
  logic [11:0]   m_syn = '0;
  logic          m_exc = 1'b0;
  string         m_tag = "R4";

  mem_fault_chk #(.ADDR_W(AW)) i_mem_fault_chk (
    .clk(clk), .rst(rst), .acc_valid(acc_valid), .acc_addr(acc_addr),
    .acc_size(acc_size), .acc_write(acc_write), .acc_reg(acc_reg),
    .stk_chk_en(stk_chk_en), .stk_lo(stk_lo), .stk_hi(stk_hi),
    .ibus_err(ibus_err), .dbus_err(dbus_err), .exc_en(exc_en),
    .cfg_ibus_exc(cfg_ibus_exc), .cfg_dbus_exc(cfg_dbus_exc),
    .fault_addr(fault_addr), .fault_syn(fault_syn), .exc_req(exc_req)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(string tag, string what, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  // Expected outcome from the requirements for the inputs currently driven.
  task automatic model();
    logic mis, stk;
    mis = acc_valid && ((acc_addr[1:0] & acc_size) != 2'b00);          // R2, R12
    stk = acc_valid && stk_chk_en && (acc_addr < stk_lo || acc_addr > stk_hi); // R5, R6
    m_exc = 1'b0;
    if (exc_en && (ibus_err || dbus_err)) begin
      m_addr = acc_addr;
      m_tag = (mis || stk) ? "R10" : "R8";
      if (ibus_err ? cfg_ibus_exc : cfg_dbus_exc) begin
        m_syn = ibus_err ? 12'd3 : 12'd4;
        m_exc = 1'b1;
      end else if (!(mis || stk)) m_tag = "R9";
    end else if (mis) begin
      m_addr = acc_addr;
      m_syn  = {(acc_size == 2'b11), acc_write, acc_reg, 5'd1};
      m_exc  = exc_en;
      m_tag  = (ibus_err || dbus_err) ? "R7" : (stk ? "R10" : "R3");
    end else if (stk) begin
      m_addr = acc_addr;
      m_syn  = 12'd7;
      m_exc  = 1'b1;
      m_tag  = "R5";
    end else begin
      m_tag = (ibus_err || dbus_err) ? "R7" :
              (!acc_valid ? "R12" : (stk_chk_en ? "R4" : "R6"));
    end
  endtask

  task automatic apply();
    model();
    @(negedge clk);
    check(m_tag, "fault_addr", fault_addr, m_addr);
    check(m_tag, "fault_syn", {20'd0, fault_syn}, {20'd0, m_syn});
    check(m_tag, "exc_req", {31'd0, exc_req}, {31'd0, m_exc});
  endtask

  initial begin : watchdog
    #(CLK_PERIOD * 150000);
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin : stim
    logic [AW-1:0] bases[4];
    logic [1:0]    sizes[3];
    bases[0] = 32'h0000_00FC; bases[1] = 32'h0000_0100;
    bases[2] = 32'h0000_01FC; bases[3] = 32'h0000_0200;
    sizes[0] = 2'd0; sizes[1] = 2'd1; sizes[2] = 2'd3;
    repeat (3) @(negedge clk);
    // R1: reset state
    check("R1", "fault_addr", fault_addr, 32'd0);
    check("R1", "fault_syn", {20'd0, fault_syn}, 32'd0);
    check("R1", "exc_req", {31'd0, exc_req}, 32'd0);
    rst = 1'b0;

    // Sweep alignment and stack window around both limits.
    for (int b = 0; b < 4; b++)
      for (int o = 0; o < 8; o++)
        for (int s = 0; s < 3; s++)
          for (int m = 0; m < 4; m++) begin
            acc_valid  = 1'b1;
            acc_addr   = bases[b] + 32'(o);
            acc_size   = sizes[s];
            acc_write  = m[0];
            acc_reg    = 5'(b * 8 + o + m);
            exc_en     = m[1];
            stk_chk_en = (o + s) % 2 == 0;
            apply();
          end

    // R11: request lasts one cycle; an idle cycle drops it.
    acc_valid = 1'b1; acc_addr = 32'h0000_0101; acc_size = 2'd1; exc_en = 1'b1;
    stk_chk_en = 1'b0; ibus_err = 1'b0; dbus_err = 1'b0;
    apply();
    check("R11", "exc_req pulse", {31'd0, exc_req}, 32'd1);
    acc_valid = 1'b0;
    apply();
    check("R11", "exc_req dropped", {31'd0, exc_req}, 32'd0);

    // R12: invalid cycles with bad address and stack window do nothing.
    acc_valid = 1'b0; acc_addr = 32'h0000_0003; acc_size = 2'd3; stk_chk_en = 1'b1;
    apply();

    // Bus error sweep with misaligned and stack-violating accesses in the same cycle.
    for (int k = 0; k < 64; k++) begin
      ibus_err     = k[0];
      dbus_err     = k[1];
      cfg_ibus_exc = k[2];
      cfg_dbus_exc = k[3];
      exc_en       = k[4];
      acc_valid    = 1'b1;
      acc_addr     = k[5] ? 32'h0000_0302 : 32'h0000_0180 + 32'(k * 4);
      acc_size     = 2'd3;
      acc_write    = k[2];
      acc_reg      = 5'(k);
      stk_chk_en   = k[5];
      apply();
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule